// File: doc/BRIEF.md
# Two-Pattern Slow-Clock Delay Test Sequencer

This block runs a two-pattern timing test on a purely combinational logic cone whose inputs sit behind an input register bank and whose outputs are caught by an output register bank. Both banks run on one fast base clock. Each bank loads only when the sequencer pulses its own enable. The input bank and the output bank therefore act as two clocks whose phase is set independently.

After an accepted start, the sequencer loads the first pattern into the input bank. It then waits a long, programmable settling interval so that the cone reaches a steady state. Next it loads the second pattern, which launches the transitions. After exactly a programmable rated interval, counted in base-clock cycles, it pulses the output bank enable. The total test is slow, but the launch-to-capture distance equals the rated period.

One cycle after capture, the sequencer compares the captured response with the expected response. It then raises done together with a pass/fail verdict. A mismatch means that some path through the cone took longer than the rated interval.

Top module: `dlytst_seq`

## Requirements
- R1: After reset, in_en_o, out_en_o, busy_o, done_o, fail_o and cfg_err_o are all 0.
- R2: A start accepted at a clock edge makes in_en_o high in the very next cycle, with vec_o equal to the first pattern. During the second in_en_o pulse, vec_o equals the second pattern.
- R3: The second in_en_o pulse comes exactly settle_i cycles after the first one.
- R4: out_en_o pulses exactly rated_i cycles after the second in_en_o pulse.
- R5: in_en_o and out_en_o are never high in the same cycle. Each pulse lasts one cycle. A test produces exactly two in_en_o pulses and one out_en_o pulse.
- R6: In the cycle after the out_en_o pulse, resp_i is compared with the expected response. done_o rises one cycle later, which is two cycles after out_en_o. fail_o is then 1 exactly when the two values differ.
- R7: done_o and fail_o hold their values until the next accepted start. In the cycle after an accepted start, done_o and fail_o read 0 and busy_o reads 1.
- R8: A start pulse while busy_o is 1 is ignored. The running test keeps its patterns, intervals and verdict.
- R9: A start with rated_i equal to 0, or with settle_i not greater than rated_i, is rejected. No enable pulses follow, busy_o stays 0, and done_o and fail_o keep their values. cfg_err_o reads 1 from the next cycle until the next accepted start clears it.
- R10: Patterns, expected response and both intervals are sampled at acceptance. Changing those inputs during a test has no effect on that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a test |
| v1_i | input | DW | First (initialising) pattern |
| v2_i | input | DW | Second (launching) pattern |
| exp_i | input | RW | Expected captured response |
| settle_i | input | CW | Cycles between the two input loads |
| rated_i | input | CW | Cycles from launch to capture |
| resp_i | input | RW | Contents of the output register bank |
| vec_o | output | DW | Pattern presented to the input bank |
| in_en_o | output | 1 | Load enable for the input bank |
| out_en_o | output | 1 | Load enable for the output bank |
| busy_o | output | 1 | A test is in progress |
| done_o | output | 1 | Verdict is valid |
| fail_o | output | 1 | Response mismatch (delay fault) |
| cfg_err_o | output | 1 | Last start was rejected for bad intervals |

## Verification
The hardest situation to produce from the ports is a capture whose outcome depends on a path delay lying right at the rated interval. A path delay one cycle shorter must pass, and one equal to the rated interval must fail. The bench models the cone as a function fed through a delay line of base-clock cycles whose depth is programmable. It then sweeps that delay across the boundary while the scoreboard predicts whether the first or the second pattern reaches the output bank. A second hard case is a start pulse, together with changed configuration inputs, that arrives in the middle of a running test. The bench drives this mid-test and checks that the scoreboard item for the original test still matches.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RATED,
        ST_CAP,
        ST_CMP
    } dts_state_e;
endpackage

// File: rtl/dts_timer.sv
module dts_timer #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dts_cfg_chk.sv
module dts_cfg_chk #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] settle_i,
    input  logic [CW-1:0] rated_i,
    output logic          ok_o
);
    logic rated_nz;
    logic settle_longer;

    assign rated_nz      = (rated_i != '0);
    assign settle_longer = (settle_i > rated_i);
    assign ok_o          = rated_nz && settle_longer;
endmodule

// File: rtl/dts_cmp.sv
module dts_cmp #(
    parameter int RW = 8
) (
    input  logic [RW-1:0] resp_i,
    input  logic [RW-1:0] exp_i,
    output logic          mismatch_o
);
    logic [RW-1:0] diff;

    for (genvar g = 0; g < RW; g++) begin : g_bit
        assign diff[g] = resp_i[g] ^ exp_i[g];
    end

    assign mismatch_o = |diff;
endmodule

// File: rtl/dlytst_seq.sv
module dlytst_seq
    import dts_pkg::*;
#(
    parameter int DW = 8,
    parameter int RW = 8,
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [DW-1:0] v1_i,
    input  logic [DW-1:0] v2_i,
    input  logic [RW-1:0] exp_i,
    input  logic [CW-1:0] settle_i,
    input  logic [CW-1:0] rated_i,
    input  logic [RW-1:0] resp_i,
    output logic [DW-1:0] vec_o,
    output logic          in_en_o,
    output logic          out_en_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          cfg_err_o
);
    typedef struct packed {
        dts_state_e    st;
        logic [DW-1:0] vec;
        logic [DW-1:0] v2;
        logic [RW-1:0] expv;
        logic [CW-1:0] rated;
        logic          in_en;
        logic          out_en;
        logic          done;
        logic          fail;
        logic          cfg_err;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cfg_ok;
    logic          mismatch;

    dts_timer #(.CW(CW)) tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    dts_cfg_chk #(.CW(CW)) cfg_i (
        .settle_i (settle_i),
        .rated_i  (rated_i),
        .ok_o     (cfg_ok)
    );

    dts_cmp #(.RW(RW)) cmp_i (
        .resp_i     (resp_i),
        .exp_i      (r_q.expv),
        .mismatch_o (mismatch)
    );

    always_comb begin
        r_d      = r_q;
        r_d.in_en  = 1'b0;
        r_d.out_en = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        r_d.st      = ST_SETTLE;
                        r_d.vec     = v1_i;
                        r_d.in_en   = 1'b1;
                        r_d.v2      = v2_i;
                        r_d.expv    = exp_i;
                        r_d.rated   = rated_i;
                        r_d.done    = 1'b0;
                        r_d.fail    = 1'b0;
                        r_d.cfg_err = 1'b0;
                        tmr_load    = 1'b1;
                        tmr_val     = settle_i - 1'b1;
                    end else begin
                        r_d.cfg_err = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    r_d.st    = ST_RATED;
                    r_d.vec   = r_q.v2;
                    r_d.in_en = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.rated - 1'b1;
                end
            end
            ST_RATED: begin
                if (tmr_zero) begin
                    r_d.st     = ST_CAP;
                    r_d.out_en = 1'b1;
                end
            end
            ST_CAP: begin
                r_d.st = ST_CMP;
            end
            ST_CMP: begin
                r_d.fail = mismatch;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign vec_o     = r_q.vec;
    assign in_en_o   = r_q.in_en;
    assign out_en_o  = r_q.out_en;
    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign fail_o    = r_q.fail;
    assign cfg_err_o = r_q.cfg_err;
endmodule

// File: rtl/dlytst_seq_chk.sv
module dlytst_seq_chk #(
    parameter int CW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic [CW-1:0] settle_i,
    input logic [CW-1:0] rated_i,
    input logic          in_en_o,
    input logic          out_en_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          cfg_err_o
);
    logic [CW:0]   since_q;
    logic [CW-1:0] rated_c;
    logic [CW-1:0] settle_c;
    logic [1:0]    np_q;
    logic          acc;

    assign acc = start_i && !busy_o && (rated_i != '0) && (settle_i > rated_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q  <= '0;
            rated_c  <= '0;
            settle_c <= '0;
            np_q     <= '0;
        end else begin
            if (in_en_o)             since_q <= {{CW{1'b0}}, 1'b1};
            else if (since_q != '1)  since_q <= since_q + 1'b1;
            if (acc) begin
                rated_c  <= rated_i;
                settle_c <= settle_i;
                np_q     <= '0;
            end else if (in_en_o && np_q != 2'd3) begin
                np_q <= np_q + 1'b1;
            end
        end
    end

    // R5
    one_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(in_en_o && out_en_o));

    // R5
    in_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_en_o |=> !in_en_o);

    // R5
    out_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_en_o |=> !out_en_o);

    // R3
    settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_en_o && np_q == 2'd1) |-> (since_q == {1'b0, settle_c}));

    // R4
    rated_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_en_o |-> (since_q == {1'b0, rated_c}));

    // R6
    done_after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(out_en_o, 2));

    // R7
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> done_o);

    // R9
    reject_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && rated_i == '0) |=> (!busy_o && cfg_err_o && !in_en_o));
endmodule

bind dlytst_seq dlytst_seq_chk #(.CW(CW)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .settle_i  (settle_i),
    .rated_i   (rated_i),
    .in_en_o   (in_en_o),
    .out_en_o  (out_en_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/dlytst_seq_tb_top.sv
module dlytst_seq_tb_top;
    localparam int DW = 8;
    localparam int RW = 8;
    localparam int CW = 12;
    localparam int HD = 16;

    typedef struct {
        logic [DW-1:0] v1;
        logic [DW-1:0] v2;
        bit            fail;
        int            settle;
        int            rated;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] v1 = '0, v2 = '0;
    logic [RW-1:0] expv = '0;
    logic [CW-1:0] settle = '0, rated = '0;
    logic [RW-1:0] resp;
    logic [DW-1:0] vec;
    logic          in_en, out_en, busy, done, fail, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    int cut_dly = 0;
    bit finished = 0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dlytst_seq #(.DW(DW), .RW(RW), .CW(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .v1_i(v1), .v2_i(v2), .exp_i(expv),
        .settle_i(settle), .rated_i(rated), .resp_i(resp),
        .vec_o(vec), .in_en_o(in_en), .out_en_o(out_en),
        .busy_o(busy), .done_o(done), .fail_o(fail), .cfg_err_o(cfg_err)
    );

    // Model of the cone under test: input bank, delay line, function, output bank
    function automatic logic [RW-1:0] cone(input logic [DW-1:0] x);
        return {x[6:0], x[7]} ^ 8'h5A;
    endfunction

    logic [DW-1:0] in_lat;
    logic [DW-1:0] hp [1:HD-1];

    always_ff @(posedge clk) begin
        if (in_en) in_lat <= vec;
        hp[1] <= in_lat;
        for (int k = 2; k < HD; k++) hp[k] <= hp[k-1];
        if (out_en) resp <= cone((cut_dly == 0) ? in_lat : hp[cut_dly]);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor and scoreboard
    int cyc = 0, np = 0, no = 0, ntot = 0;
    int t1 = 0, t2 = 0, tout = 0;
    logic [DW-1:0] vec1 = '0, vec2 = '0;
    bit done_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (in_en && out_en) chk(0, "R5 both enables", 1, 0);
            if (in_en) begin
                if (np == 0) begin t1 = cyc; vec1 = vec; end
                else begin t2 = cyc; vec2 = vec; end
                np++; ntot++;
            end
            if (out_en) begin tout = cyc; no++; ntot++; end
            if (done && !done_prev) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R6 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(vec1 == it.v1, "R2 first pattern", int'(vec1), int'(it.v1));
                    chk(vec2 == it.v2, "R2 second pattern", int'(vec2), int'(it.v2));
                    chk(t2 - t1 == it.settle, "R3 settle gap", t2 - t1, it.settle);
                    chk(tout - t2 == it.rated, "R4 rated gap", tout - t2, it.rated);
                    chk(np == 2 && no == 1, "R5 pulse count", np * 10 + no, 21);
                    chk(fail == it.fail, "R6 verdict", int'(fail), int'(it.fail));
                    chk(cyc - tout == 2, "R6 done timing", cyc - tout, 2);
                end
                np = 0; no = 0;
            end
            done_prev = done;
        end
    end

    task automatic launch(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [RW-1:0] e, input int s, input int r, input int d);
        item_t it;
        logic [RW-1:0] seen;
        cut_dly = d;
        seen = (d >= r) ? cone(a) : cone(b);
        it.v1 = a; it.v2 = b; it.settle = s; it.rated = r;
        it.fail = (seen != e);
        sb_q.push_back(it);
        v1 = a; v2 = b; expv = e;
        settle = CW'(s); rated = CW'(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done && !busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!in_en && !out_en, "R1 enables", int'(in_en) + int'(out_en), 0);
        chk(!busy && !done, "R1 busy/done", int'(busy) + int'(done), 0);
        chk(!fail && !cfg_err, "R1 fail/cfg_err", int'(fail) + int'(cfg_err), 0);

        // Passing test, path delay below rated interval
        launch(8'h3C, 8'hC3, cone(8'hC3), 10, 4, 2);
        wait_done();
        // R7 done holds
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", int'(done), 1);
        chk(fail == 1'b0, "R7 fail holds", int'(fail), 0);

        // Slow path fails; check clearing after acceptance (R7)
        launch(8'h0F, 8'hF0, cone(8'hF0), 12, 4, 6);
        chk(!done && !fail && busy, "R7 cleared on start",
            int'(done) * 4 + int'(fail) * 2 + int'(busy), 1);
        wait_done();
        repeat (3) @(negedge clk);
        chk(fail == 1'b1, "R7 fail holds after fault", int'(fail), 1);

        // Boundary: smallest legal intervals
        launch(8'h81, 8'h18, cone(8'h18), 2, 1, 0);
        wait_done();

        // Wrong expected response
        launch(8'h55, 8'hAA, cone(8'hAA) ^ 8'h01, 6, 3, 0);
        wait_done();

        // Delay exactly at the rated interval fails, one below passes
        launch(8'h12, 8'hED, cone(8'hED), 14, 5, 5);
        wait_done();
        launch(8'h12, 8'hED, cone(8'hED), 14, 5, 4);
        wait_done();

        // R8 / R10: start and new inputs mid-test are ignored
        launch(8'h66, 8'h99, cone(8'h99), 20, 5, 3);
        repeat (4) @(negedge clk);
        v1 = 8'hFF; v2 = 8'h00; expv = 8'h00; settle = 12'd3; rated = 12'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 still busy", int'(busy), 1);
        repeat (20) @(negedge clk);
        v1 = 8'h01; v2 = 8'h02;
        wait_done();
        chk(sb_q.size() == 0, "R10 single verdict", sb_q.size(), 0);

        // R9 rejections
        snap = ntot;
        settle = 12'd8; rated = 12'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err && !busy, "R9 rated zero rejected", int'(cfg_err) * 2 + int'(busy), 2);
        repeat (5) @(negedge clk);
        chk(ntot == snap, "R9 no enables after zero", ntot - snap, 0);
        chk(done == 1'b1, "R9 done kept", int'(done), 1);
        settle = 12'd3; rated = 12'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(cfg_err && !busy && ntot == snap, "R9 settle not longer rejected",
            int'(cfg_err) * 2 + int'(busy), 2);
        launch(8'hA5, 8'h5A, cone(8'h5A), 9, 2, 1);
        chk(!cfg_err, "R9 cleared by accepted start", int'(cfg_err), 0);
        wait_done();

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule